// File: doc/BRIEF.md
# Dual Channel Limit Timer with Restart and Non-Restart Limit Writes

The block holds two counting channels behind one small register bus. Channel 0 is the interrupting system timer. Channel 1 is a user counter that only advances while its run bit is set. Both channels count strobes on the `tick` input, which a divider outside the block derives from a 2 MHz reference, so each step is 500 ns. A channel counts upward from 1. When the next step would reach the programmed limit, the count returns to 1 and a sticky "limit reached" flag is raised. A limit of N therefore gives a period of N-1 steps.

Each channel decodes five word slots. The limit can be written through two aliases: one restarts the count and one leaves the count running. The slots are limit, count, non-restarting limit alias, an inert slot, and a control word. Count and limit values occupy a 22-bit field whose lowest bit sits at bit 9 of the bus word, and the flag is reported in bit 31. In channel 0 the control bit puts the timer in user mode, which masks its interrupt. In channel 1 the control bit is the run/halt bit.

Software acknowledges the interrupt by reading the limit slot of channel 0.

Top module: `limit_timer_pair`

## Requirements
- R1: After synchronous reset, every count, limit, flag and control bit is 0 and `irq` is low.
- R2: On each cycle with `tick` high, an advancing channel adds 1 to its count. When the limit is at least 2 and count+1 is at least the limit, the count becomes 1 and the flag is set.
- R3: A write to slot 0 (byte offset 0) loads the limit from write-data bits [30:9], sets the count to 1 and clears the flag. This takes precedence over a tick in the same cycle.
- R4: A write to slot 2 (byte offset 8) loads the limit from bits [30:9] and leaves the count and the flag untouched.
- R5: Reads of slots 0 and 2 return the limit, and reads of slot 1 (offset 4) return the count, each in bits [30:9] with the flag in bit 31 and zeros elsewhere. `bus_rdata` is 0 when no read is in progress.
- R6: A read of slot 0 clears that channel's flag at the clock edge, unless a wrap sets the flag in the same cycle, in which case the flag stays set.
- R7: `irq` is high exactly when the channel 0 flag is set and the channel 0 control bit is 0.
- R8: Slot 4 (offset 16) holds a single control bit in bit 0, written from write-data bit 0. It reads back with bits [31:1] equal to zero.
- R9: Channel 1 is selected by address bit 5. Its count advances on `tick` only while its control bit is 1, and holds while that bit is 0. Channel 0 advances on every tick.
- R10: Slot 3 (offset 12) and slots 5 to 7 read as 0. Writes to them, and writes to the count slot, change no state.
- R11: With a limit of 0 or 1, the count runs freely without wrapping to 1 and the flag is not set.
- R12: The channel 1 flag sets and clears under the same rules as channel 0 but never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count strobe at the 500 ns step rate |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address: bit 5 selects the channel, bits [4:2] select the slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read strobe |
| irq | output | 1 | Interrupt from channel 0 |

## Verification
The properties assume that `rst` is held high from time zero through at least one edge. They also assume that each access lasts exactly one cycle, so a flag clear can always be traced to a slot 0 read or write in the previous cycle. The stimulus keeps every address word-aligned and inside the 64-byte window. Both the directed and the random phases drive `tick` as a level sampled each clock. Random limit values are kept small so that wraps, and read-during-wrap collisions, occur often.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int WORD_W   = 32;
    localparam int CNT_W    = 22;
    localparam int CNT_LSB  = 9;
    localparam int FLAG_BIT = 31;
    localparam int NUM_CH   = 2;
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WIDX_W   = 3;
    localparam int ADDR_W   = 6;
    localparam int WIDX_LSB = 2;
    localparam int CH_LSB   = WIDX_LSB + WIDX_W;

    // slot order on the bus; the order is decoded by software
    typedef enum logic [WIDX_W-1:0] {
        SLOT_LIMIT    = 3'd0,
        SLOT_COUNT    = 3'd1,
        SLOT_LIMIT_NR = 3'd2,
        SLOT_IDLE     = 3'd3,
        SLOT_CTRL     = 3'd4
    } slot_e;

    typedef struct packed {
        logic             load_lim;
        logic             load_lim_nr;
        logic             load_ctrl;
        logic             ack_flag;
        logic [CNT_W-1:0] field;
        logic             ctrl_bit;
    } chan_cmd_t;

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] lim;
        logic [CNT_W-1:0] cnt;
    } chan_state_t;

    function automatic logic [WORD_W-1:0] place_field(input logic flag,
                                                      input logic [CNT_W-1:0] v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[FLAG_BIT] = flag;
        w[CNT_LSB +: CNT_W] = v;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] take_field(input logic [WORD_W-1:0] w);
        return w[CNT_LSB +: CNT_W];
    endfunction

    // wrap when the next step would meet or pass an active limit
    function automatic logic reaches_limit(input logic [CNT_W-1:0] cnt,
                                           input logic [CNT_W-1:0] lim);
        return (lim >= CNT_W'(2)) &&
               (({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, lim});
    endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
(
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output chan_cmd_t           cmd [NUM_CH],
    output logic [CH_W-1:0]     rd_ch,
    output slot_e               rd_slot,
    output logic                rd_active
);

    slot_e           slot;
    logic [CH_W-1:0] ch;
    logic            unused_bits;

    assign slot      = slot_e'(bus_addr[WIDX_LSB +: WIDX_W]);
    assign ch        = bus_addr[CH_LSB +: CH_W];
    assign rd_ch     = ch;
    assign rd_slot   = slot;
    assign rd_active = bus_sel && !bus_wr;

    assign unused_bits = ^{bus_addr[WIDX_LSB-1:0],
                           bus_wdata[WORD_W-1:CNT_LSB+CNT_W],
                           bus_wdata[CNT_LSB-1:1]};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = bus_sel && (ch == CH_W'(c));
        always_comb begin
            cmd[c].load_lim    = hit &&  bus_wr && (slot == SLOT_LIMIT);
            cmd[c].load_lim_nr = hit &&  bus_wr && (slot == SLOT_LIMIT_NR);
            cmd[c].load_ctrl   = hit &&  bus_wr && (slot == SLOT_CTRL);
            cmd[c].ack_flag    = hit && !bus_wr && (slot == SLOT_LIMIT);
            cmd[c].field       = take_field(bus_wdata);
            cmd[c].ctrl_bit    = bus_wdata[0];
        end
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  chan_cmd_t   cmd,
    output chan_state_t st
);

    chan_state_t st_q;
    logic        wrap;

    assign wrap = step && reaches_limit(st_q.cnt, st_q.lim);
    assign st   = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (cmd.load_lim) begin
            st_q.lim  <= cmd.field;
            st_q.cnt  <= CNT_W'(1);
            st_q.flag <= 1'b0;
        end else begin
            if (cmd.load_lim_nr) begin
                st_q.lim <= cmd.field;
            end
            if (step) begin
                st_q.cnt <= wrap ? CNT_W'(1) : st_q.cnt + CNT_W'(1);
            end
            if (wrap) begin
                st_q.flag <= 1'b1;
            end else if (cmd.ack_flag) begin
                st_q.flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter bit USER_CTR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  chan_cmd_t         cmd,
    input  slot_e             rd_slot,
    output logic [WORD_W-1:0] rdata,
    output logic              irq,
    output chan_state_t       st,
    output logic              ctrl
);

    logic ctrl_q;
    logic run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= 1'b0;
        end else if (cmd.load_ctrl) begin
            ctrl_q <= cmd.ctrl_bit;
        end
    end

    assign ctrl = ctrl_q;

    if (USER_CTR) begin : g_user
        assign run = ctrl_q;
        assign irq = 1'b0;
    end else begin : g_sys
        assign run = 1'b1;
        assign irq = st.flag && !ctrl_q;
    end

    tmr_count_core u_core (
        .clk  (clk),
        .rst  (rst),
        .step (tick && run),
        .cmd  (cmd),
        .st   (st)
    );

    always_comb begin
        unique case (rd_slot)
            SLOT_LIMIT, SLOT_LIMIT_NR: rdata = place_field(st.flag, st.lim);
            SLOT_COUNT:                rdata = place_field(st.flag, st.cnt);
            SLOT_CTRL:                 rdata = {{(WORD_W-1){1'b0}}, ctrl_q};
            default:                   rdata = '0;
        endcase
    end

endmodule

// File: rtl/limit_timer_pair.sv
module limit_timer_pair
    import tmr_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [tmr_pkg::ADDR_W-1:0] bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      irq
);

    chan_cmd_t         cmd      [NUM_CH];
    chan_state_t       ch_st    [NUM_CH];
    logic [WORD_W-1:0] ch_rdata [NUM_CH];
    logic [NUM_CH-1:0] ch_irq;
    logic [NUM_CH-1:0] ch_ctrl;
    logic [CH_W-1:0]   rd_ch;
    slot_e             rd_slot;
    logic              rd_active;

    tmr_bus_decode u_dec (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd),
        .rd_ch     (rd_ch),
        .rd_slot   (rd_slot),
        .rd_active (rd_active)
    );

    // channel 0 interrupts; the others are gated user counters
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tmr_channel #(.USER_CTR(c != 0)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cmd     (cmd[c]),
            .rd_slot (rd_slot),
            .rdata   (ch_rdata[c]),
            .irq     (ch_irq[c]),
            .st      (ch_st[c]),
            .ctrl    (ch_ctrl[c])
        );
    end

    assign bus_rdata = rd_active ? ch_rdata[rd_ch] : '0;
    assign irq       = |ch_irq;

endmodule

// File: rtl/limit_timer_pair_chk.sv
module limit_timer_pair_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq,
    input chan_state_t       st0,
    input chan_state_t       st1,
    input logic [1:0]        ctrl
);

    logic a_ch1;
    logic [WIDX_W-1:0] a_slot;
    logic lim_wr0, lim_rd0, nr_wr0, lim_wr1;
    logic wrap_due0;

    assign a_ch1   = bus_addr[CH_LSB];
    assign a_slot  = bus_addr[WIDX_LSB +: WIDX_W];
    assign lim_wr0 = bus_sel &&  bus_wr && !a_ch1 && (a_slot == 3'd0);
    assign lim_rd0 = bus_sel && !bus_wr && !a_ch1 && (a_slot == 3'd0);
    assign nr_wr0  = bus_sel &&  bus_wr && !a_ch1 && (a_slot == 3'd2);
    assign lim_wr1 = bus_sel &&  bus_wr &&  a_ch1 && (a_slot == 3'd0);
    assign wrap_due0 = (st0.lim >= CNT_W'(2)) &&
                       (({1'b0, st0.cnt} + 23'd1) >= {1'b0, st0.lim});

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (st0 == '0 && st1 == '0 && ctrl == 2'b00 && !irq)); // R1

    AST_WRAP_TO_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !lim_wr0 && wrap_due0) |=> (st0.cnt == CNT_W'(1) && st0.flag)); // R2

    AST_LIMIT_RESTART: assert property (@(posedge clk) disable iff (rst)
        lim_wr0 |=> (st0.cnt == CNT_W'(1) && !st0.flag)); // R3

    AST_NR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (nr_wr0 && !tick) |=> ($stable(st0.cnt) && $stable(st0.flag))); // R4

    AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(st0.flag) |-> $past(lim_rd0 || lim_wr0)); // R6

    AST_USER_MODE_MASK: assert property (@(posedge clk) disable iff (rst)
        ctrl[0] |-> !irq); // R7

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[1] && !lim_wr1) |=> $stable(st1.cnt)); // R9

endmodule

bind limit_timer_pair limit_timer_pair_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq      (irq),
    .st0      (ch_st[0]),
    .st1      (ch_st[1]),
    .ctrl     (ch_ctrl)
);

// File: tb/test_limit_timer_pair.sv
module test_limit_timer_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    logic [21:0] m_lim [2];
    logic [21:0] m_cnt [2];
    logic        m_flg [2];
    logic        m_ctl [2];

    always #10 clk = ~clk;

    limit_timer_pair i_limit_timer_pair (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [31:0] lw(input int v);
        logic [21:0] f;
        f = v[21:0];
        return {1'b0, f, 9'b0};
    endfunction

    function automatic logic [31:0] m_read(input logic [5:0] a);
        int c;
        c = int'(a[5]);
        case (a[4:2])
            3'd0, 3'd2: return {m_flg[c], m_lim[c], 9'b0};
            3'd1:       return {m_flg[c], m_cnt[c], 9'b0};
            3'd4:       return {31'b0, m_ctl[c]};
            default:    return 32'h0;
        endcase
    endfunction

    task automatic m_reset();
        for (int c = 0; c < 2; c++) begin
            m_lim[c] = '0; m_cnt[c] = '0; m_flg[c] = 1'b0; m_ctl[c] = 1'b0;
        end
    endtask

    task automatic m_update(input logic t, input logic s, input logic w,
                            input logic [5:0] a, input logic [31:0] d);
        for (int c = 0; c < 2; c++) begin
            logic hit, adv, wrap;
            logic [2:0] sl;
            hit  = s && (int'(a[5]) == c);
            sl   = a[4:2];
            adv  = t && (c == 0 || m_ctl[c]);
            wrap = adv && (m_lim[c] >= 22'd2) &&
                   (({1'b0, m_cnt[c]} + 23'd1) >= {1'b0, m_lim[c]});
            if (hit && w && sl == 3'd0) begin
                m_lim[c] = d[30:9]; m_cnt[c] = 22'd1; m_flg[c] = 1'b0;
            end else begin
                if (adv) m_cnt[c] = wrap ? 22'd1 : m_cnt[c] + 22'd1;
                if (wrap) m_flg[c] = 1'b1;
                else if (hit && !w && sl == 3'd0) m_flg[c] = 1'b0;
                if (hit && w && sl == 3'd2) m_lim[c] = d[30:9];
            end
            if (hit && w && sl == 3'd4) m_ctl[c] = d[0];
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: drive after negedge, compare mid-cycle, update model at the edge
    task automatic step(input logic t, input logic s, input logic w,
                        input logic [5:0] a, input logic [31:0] d, input string tag);
        tick = t; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        #2;
        check((s && !w) ? tag : "R5 idle", bus_rdata, (s && !w) ? m_read(a) : 32'h0);
        check("R7 irq", {31'b0, irq}, {31'b0, m_flg[0] && !m_ctl[0]});
        @(posedge clk);
        m_update(t, s, w, a, d);
        @(negedge clk);
    endtask

    task automatic rd(input logic t, input logic [5:0] a, input string tag);
        step(t, 1'b1, 1'b0, a, 32'h0, tag);
    endtask

    task automatic wr(input logic t, input logic [5:0] a, input logic [31:0] d, input string tag);
        step(t, 1'b1, 1'b1, a, d, tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every slot in both channels
        for (int a = 0; a < 64; a += 4) rd(1'b0, 6'(a), "R1 reset");

        // R3 then R2: restart with limit 5, count 1..4 then wrap
        wr(1'b0, 6'h00, lw(5) | 32'h8000_01FF, "R3");
        rd(1'b0, 6'h04, "R3 restart count");
        for (int i = 0; i < 6; i++) rd(1'b1, 6'h04, "R2 count");
        rd(1'b0, 6'h08, "R5 alias keeps flag");
        rd(1'b0, 6'h00, "R6 read limit");
        rd(1'b0, 6'h04, "R6 flag cleared");

        // R6: read of slot 0 while the wrap happens keeps the flag
        wr(1'b0, 6'h00, lw(3), "R3");
        rd(1'b1, 6'h04, "R2");
        rd(1'b1, 6'h00, "R6 collide");
        rd(1'b0, 6'h04, "R6 set wins");
        rd(1'b0, 6'h00, "R6 clear");
        rd(1'b0, 6'h04, "R6 cleared");

        // R4: non-restarting alias mid-count
        wr(1'b0, 6'h00, lw(20), "R3");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 6'h0, 32'h0, "R2");
        wr(1'b0, 6'h08, lw(9), "R4");
        rd(1'b0, 6'h04, "R4 count kept");
        rd(1'b0, 6'h00, "R4 new limit");
        for (int i = 0; i < 5; i++) rd(1'b1, 6'h04, "R4 wrap at new limit");

        // R8 and R7: user mode masks the interrupt while the flag is set
        wr(1'b0, 6'h10, 32'hFFFF_FFFF, "R8");
        rd(1'b0, 6'h10, "R8 ctrl readback");
        rd(1'b0, 6'h04, "R7 flag still set");
        wr(1'b0, 6'h10, 32'hFFFF_FFFE, "R8");
        rd(1'b0, 6'h10, "R8 ctrl cleared");

        // R10: idle slots and count slot ignore writes
        wr(1'b0, 6'h0C, 32'hFFFF_FFFF, "R10");
        wr(1'b0, 6'h04, lw(77), "R10");
        wr(1'b0, 6'h1C, 32'hFFFF_FFFF, "R10");
        rd(1'b0, 6'h0C, "R10 idle");
        rd(1'b0, 6'h1C, "R10 upper slot");
        rd(1'b0, 6'h04, "R10 count unchanged");
        rd(1'b0, 6'h00, "R10 limit unchanged");

        // R11: limit 1 runs freely
        wr(1'b0, 6'h00, lw(1), "R11");
        for (int i = 0; i < 6; i++) rd(1'b1, 6'h04, "R11 free run");
        wr(1'b0, 6'h08, lw(0), "R11");
        for (int i = 0; i < 3; i++) rd(1'b1, 6'h04, "R11 limit zero");

        // R9 and R12: user counter gated by its run bit
        wr(1'b0, 6'h20, lw(4), "R9");
        for (int i = 0; i < 4; i++) rd(1'b1, 6'h24, "R9 halted");
        wr(1'b0, 6'h30, 32'h1, "R9 run");
        for (int i = 0; i < 6; i++) rd(1'b1, 6'h24, "R12 user wrap no irq");
        wr(1'b0, 6'h30, 32'h0, "R9 halt");
        for (int i = 0; i < 3; i++) rd(1'b1, 6'h24, "R9 held");
        rd(1'b0, 6'h20, "R12 ack");
        rd(1'b0, 6'h24, "R12 cleared");

        // mixed random traffic with small limits
        for (int i = 0; i < 600; i++) begin
            logic [5:0]  a;
            logic [31:0] d;
            logic        s, w;
            string       tg;
            a  = {$urandom_range(0, 1) == 1, 3'($urandom_range(0, 5)), 2'b00};
            d  = ($urandom() & 32'h8000_01FF) | lw($urandom_range(0, 9));
            s  = $urandom_range(0, 2) != 0;
            w  = $urandom_range(0, 3) == 0;
            case (a[4:2])
                3'd0, 3'd2: tg = "R5 rand limit";
                3'd1:       tg = "R2 rand count";
                3'd4:       tg = "R8 rand ctrl";
                default:    tg = "R10 rand idle";
            endcase
            step($urandom_range(0, 1) == 1, s, w, a, d, tg);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule